// File: doc/BRIEF.md
# Cartridge Bus Address Decoder

This block sits between a processor's cartridge-space bus and two targets: a byte-wide ROM array and a one-bit serial EEPROM backup port. For each request it decides whether the access belongs to the EEPROM or to the ROM. The choice depends on the request address, on a configuration bit saying the backup is EEPROM, and on the ROM size. The position of the EEPROM window moves with the ROM size. For a large ROM the window is the top 256 bytes of the 32 MiB index space. For a ROM of 16 MiB or less it is the whole region whose top address byte is 0x0D.

Reads that go to the ROM are built little-endian from up to four consecutive bytes. The ROM side supplies four byte lanes beginning at the masked index. Any byte whose index lies at or beyond the ROM length is replaced by an open-bus pattern taken from its own index. Writes that hit the EEPROM window forward one serial bit. Other writes produce no response. Every result is registered and appears on the cycle after the request.

Top module: `cart_bus_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, rsp_valid, rsp_data, eep_sel, eep_wr and eep_bit are all zero after that edge.
- R2: A ROM read accepted at a clock edge shows rsp_valid=1 after that edge. Byte k of the result (bits 8k+7:8k) is the ROM byte at index (req_addr & 0x1FFFFFF) + k, and rom_lanes[8k+7:8k] carries the byte at index rom_addr + k.
- R3: With cfg_eeprom=1 and cfg_rom_bytes > 0x1000000, a masked address from 0x1FFFF00 to 0x1FFFFFF selects the EEPROM; masked address 0x1FFFEFF does not.
- R4: With cfg_eeprom=1 and cfg_rom_bytes <= 0x1000000, an address whose bits 31:24 equal 0x0D selects the EEPROM and a masked address of 0x1FFFF00 with another top byte does not. With a large ROM, a top byte of 0x0D is decoded as a ROM access.
- R5: With cfg_eeprom=0, eep_sel is never raised and addresses with top byte 0x0D read the ROM.
- R6: An EEPROM write gives eep_sel=1, eep_wr=1 and eep_bit equal to bit 0 of req_wdata, one cycle later.
- R7: An EEPROM read gives eep_sel=1, eep_wr=0, rsp_valid=1 and rsp_data=0, one cycle later.
- R8: A ROM byte at index i >= cfg_rom_bytes reads as bits 16:9 of i when i is odd and bits 8:1 of i when i is even. With an empty ROM, bytes 0 to 5 read 00,00,01,00,02,00.
- R9: req_size encodes 00 byte, 01 halfword, 10 and 11 word. Result bytes above the access size read as zero.
- R10: A write outside the EEPROM window leaves rsp_valid, eep_sel, eep_wr and eep_bit at zero on the next cycle.
- R11: cfg_rom_bytes equal to 0x1000000 exactly counts as a small ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write value |
| cfg_eeprom | input | 1 | Backup is a serial EEPROM |
| cfg_rom_bytes | input | 26 | ROM length in bytes |
| rom_addr | output | 25 | Masked ROM index of lane 0 |
| rom_lanes | input | 32 | ROM bytes at rom_addr+0..3, lane k in bits 8k+7:8k |
| rsp_valid | output | 1 | Read result present |
| rsp_data | output | 32 | Read result |
| eep_sel | output | 1 | EEPROM access strobe |
| eep_wr | output | 1 | EEPROM access is a write |
| eep_bit | output | 1 | Serial bit for an EEPROM write |

## Verification
On every cycle the assertions check these rules: an EEPROM select requires the EEPROM configuration; the forwarded serial bit equals bit 0 of the last write value; EEPROM reads return zero data; writes produce no read response; byte reads carry zero upper bytes; and a large-ROM select lies in the top window. Only the bench scenarios can show that the window lies in the right place on both sides of the 16 MiB boundary, including the exact 0x1000000 size. The same holds for the little-endian assembly, for the open-bus pattern where a read crosses the ROM end or the ROM is empty, and for the top-byte 0x0D tag being ignored on a large ROM.

// File: rtl/cbd_pkg.sv
// Package: shared types of the cartridge bus decoder.
// Assumes: size codes are fixed by the processor bus (00 byte, 01 half, 1x word).
package cbd_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } acc_size_e;

    // Number of result bytes an access size keeps.
    function automatic int unsigned size_bytes(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/cbd_window.sv
// Module: EEPROM window decode.
// Decides whether an address falls in the EEPROM window. For a large ROM
// the window is the top WIN_BYTES of the masked index space. For a small
// ROM it is every address whose top byte equals SMALL_TAG.
// Assumes: purely combinational; it is qualified by the request strobe outside.
module cbd_window #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ROM_AW      = 25,
    parameter int unsigned SIZE_W      = 26,
    parameter logic [7:0]  SMALL_TAG   = 8'h0D,
    parameter int unsigned LARGE_LIMIT = 32'h0100_0000,
    parameter int unsigned WIN_BYTES   = 256
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_eeprom,
    input  logic [SIZE_W-1:0] rom_bytes,
    output logic              hit
);
    localparam logic [ROM_AW-1:0] HI_BASE = ROM_AW'((64'd1 << ROM_AW) - 64'(WIN_BYTES));

    logic large_rom;
    logic hi_hit;
    logic tag_hit;

    // Select between the top-window test and the tag test by ROM size.
    always_comb begin
        large_rom = rom_bytes > SIZE_W'(LARGE_LIMIT);
        hi_hit    = addr[ROM_AW-1:0] >= HI_BASE;
        tag_hit   = addr[ADDR_W-1 -: 8] == SMALL_TAG;
        hit       = cfg_eeprom && (large_rom ? hi_hit : tag_hit);
    end
endmodule

// File: rtl/cbd_lane.sv
// Module: one result byte lane.
// Forms the index base+LANE. It passes the ROM byte when the index is
// inside the ROM. Otherwise it returns the open-bus byte: a byte of
// (index >> 1) & 0xFFFF, with index bit 0 choosing the upper byte.
// Assumes: the ROM byte input already belongs to index base+LANE.
module cbd_lane #(
    parameter int unsigned ROM_AW = 25,
    parameter int unsigned LANE   = 0
) (
    input  logic [ROM_AW-1:0] base,
    input  logic [ROM_AW:0]   rom_bytes,
    input  logic [7:0]        rom_byte,
    output logic [7:0]        byte_out
);
    localparam int unsigned IDX_W = ROM_AW + 1;

    logic [IDX_W-1:0] idx;
    logic [7:0]       open_bus;

    // Choose the ROM byte or the address-derived pattern.
    always_comb begin
        idx      = {1'b0, base} + IDX_W'(LANE);
        open_bus = idx[0] ? idx[16:9] : idx[8:1];
        byte_out = (idx < rom_bytes) ? rom_byte : open_bus;
    end
endmodule

// File: rtl/cbd_pack.sv
// Module: result packer.
// Keeps the low bytes that the access size covers and clears the rest.
// Assumes: lane 0 is the least significant byte (little-endian).
module cbd_pack
    import cbd_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  acc_size_e            size,
    input  logic [LANES*8-1:0]   lanes,
    output logic [LANES*8-1:0]   data
);
    for (genvar k = 0; k < LANES; k++) begin : g_keep
        // Pass lane k only when the access covers it.
        always_comb begin
            data[8*k +: 8] = (k < size_bytes(size)) ? lanes[8*k +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/cart_bus_decoder.sv
// Module: cartridge bus address decoder (top).
// Routes each request to the EEPROM port or the ROM. It builds
// little-endian reads with open-bus fill past the ROM end and registers
// every result for one cycle.
// Assumes: rom_lanes is a same-cycle function of rom_addr; the ROM size
// does not exceed 2**ROM_AW bytes.
module cart_bus_decoder
    import cbd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ROM_AW      = 25,
    parameter int unsigned LANES       = 4,
    parameter int unsigned LARGE_LIMIT = 32'h0100_0000,
    parameter int unsigned WIN_BYTES   = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LANES*8-1:0]   req_wdata,
    input  logic                 cfg_eeprom,
    input  logic [ROM_AW:0]      cfg_rom_bytes,
    output logic [ROM_AW-1:0]    rom_addr,
    input  logic [LANES*8-1:0]   rom_lanes,
    output logic                 rsp_valid,
    output logic [LANES*8-1:0]   rsp_data,
    output logic                 eep_sel,
    output logic                 eep_wr,
    output logic                 eep_bit
);
    localparam int unsigned DATA_W  = LANES * 8;
    localparam int unsigned SIZE_W  = ROM_AW + 1;
    localparam logic [ROM_AW-1:0] HI_BASE = ROM_AW'((64'd1 << ROM_AW) - 64'(WIN_BYTES));

    logic              win_hit;
    logic [DATA_W-1:0] lane_bytes;
    logic [DATA_W-1:0] packed_data;
    acc_size_e         size_e;

    // Drive the ROM index from the masked address.
    always_comb begin
        rom_addr = req_addr[ROM_AW-1:0];
        size_e   = acc_size_e'(req_size);
    end

    cbd_window #(
        .ADDR_W     (ADDR_W),
        .ROM_AW     (ROM_AW),
        .SIZE_W     (SIZE_W),
        .SMALL_TAG  (8'h0D),
        .LARGE_LIMIT(LARGE_LIMIT),
        .WIN_BYTES  (WIN_BYTES)
    ) u_window (
        .addr      (req_addr),
        .cfg_eeprom(cfg_eeprom),
        .rom_bytes (cfg_rom_bytes),
        .hit       (win_hit)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        cbd_lane #(
            .ROM_AW(ROM_AW),
            .LANE  (k)
        ) u_lane (
            .base     (req_addr[ROM_AW-1:0]),
            .rom_bytes(cfg_rom_bytes),
            .rom_byte (rom_lanes[8*k +: 8]),
            .byte_out (lane_bytes[8*k +: 8])
        );
    end

    cbd_pack #(
        .LANES(LANES)
    ) u_pack (
        .size (size_e),
        .lanes(lane_bytes),
        .data (packed_data)
    );

    // Register the routed result for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            eep_sel   <= 1'b0;
            eep_wr    <= 1'b0;
            eep_bit   <= 1'b0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_data  <= (req_valid && !req_write && !win_hit) ? packed_data : '0;
            eep_sel   <= req_valid && win_hit;
            eep_wr    <= req_valid && req_write && win_hit;
            eep_bit   <= (req_valid && req_write && win_hit) ? req_wdata[0] : 1'b0;
        end
    end

    // R5: the EEPROM is only selected when it is configured.
    p_sel_needs_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eep_sel |-> $past(cfg_eeprom));

    // R6: forwarded serial bit is bit 0 of the write value.
    p_serial_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eep_sel && eep_wr) |-> (eep_bit == $past(req_wdata[0])));

    // R7: EEPROM read returns a zero result.
    p_eep_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eep_sel && !eep_wr) |-> (rsp_valid && rsp_data == '0));

    // R10: writes never produce a read response.
    p_write_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write) |-> !rsp_valid);

    // R9: a byte read clears the upper result bytes.
    p_byte_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_size) == 2'b00) |-> (rsp_data[DATA_W-1:8] == '0));

    // R3: large-ROM EEPROM selects lie in the top window.
    p_large_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eep_sel && $past(cfg_rom_bytes) > SIZE_W'(LARGE_LIMIT))
            |-> ($past(req_addr[ROM_AW-1:0]) >= HI_BASE));
endmodule

// File: tb/sim_cart_bus_decoder.sv
module sim_cart_bus_decoder;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          due;
        logic        rv;
        logic [31:0] data;
        logic        sel;
        logic        wr;
        logic        bitv;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        cfg_eeprom = 1'b0;
    logic [25:0] cfg_rom_bytes = 26'h100;
    logic [24:0] rom_addr;
    logic [31:0] rom_lanes;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        eep_sel;
    logic        eep_wr;
    logic        eep_bit;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bus_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_eeprom(cfg_eeprom), .cfg_rom_bytes(cfg_rom_bytes), .rom_addr(rom_addr),
        .rom_lanes(rom_lanes), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .eep_sel(eep_sel), .eep_wr(eep_wr), .eep_bit(eep_bit)
    );

    function automatic logic [7:0] romb(input logic [25:0] i);
        return 8'(i * 13) ^ i[16:9];
    endfunction

    // ROM model: lane k holds the byte at rom_addr + k.
    always_comb begin
        for (int k = 0; k < 4; k++) rom_lanes[8*k +: 8] = romb({1'b0, rom_addr} + 26'(k));
    end

    function automatic logic model_hit(input logic [31:0] a);
        if (!cfg_eeprom) return 1'b0;
        if (cfg_rom_bytes > 26'h100_0000) return a[24:0] >= 25'h1FF_FF00;
        return a[31:24] == 8'h0D;
    endfunction

    function automatic logic [7:0] model_byte(input logic [25:0] i);
        if (i < cfg_rom_bytes) return romb(i);
        return i[0] ? i[16:9] : i[8:1];
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Driver: present one request and queue its expected result.
    task automatic issue(input string tag, input logic w, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] wd);
        exp_t e;
        int n;
        logic h;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
        h = model_hit(a);
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        e.due = cyc + 1; e.tag = tag;
        e.rv = !w; e.sel = h; e.wr = w && h; e.bitv = w && h && wd[0];
        e.data = '0;
        if (!w && !h)
            for (int k = 0; k < n; k++) e.data[8*k +: 8] = model_byte({1'b0, a[24:0]} + 26'(k));
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare results a quarter period after each edge.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #(CLK_PERIOD/4);
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "rsp_valid", 32'(rsp_valid), 32'(e.rv));
            check(e.tag, "rsp_data", rsp_data, e.data);
            check(e.tag, "eep_sel", 32'(eep_sel), 32'(e.sel));
            check(e.tag, "eep_wr", 32'(eep_wr), 32'(e.wr));
            check(e.tag, "eep_bit", 32'(eep_bit), 32'(e.bitv));
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0D00_0000; req_wdata = 32'h1;
        cfg_eeprom = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs at zero even with a request pending
        check("R1", "rsp_valid", 32'(rsp_valid), 0);
        check("R1", "rsp_data", rsp_data, 0);
        check("R1", "eep_sel", 32'(eep_sel), 0);
        check("R1", "eep_bit", 32'(eep_bit), 0);
        req_valid = 1'b0; cfg_eeprom = 1'b0;
        rst_n = 1'b1;
        idle(1);

        // R2 and R9: in-range reads of each size
        cfg_rom_bytes = 26'h100;
        issue("R2", 1'b0, 2'b10, 32'h0800_0010, 0);
        issue("R2", 1'b0, 2'b01, 32'h0800_0021, 0);
        issue("R9", 1'b0, 2'b00, 32'h0800_0033, 0);
        issue("R9", 1'b0, 2'b11, 32'h0800_0044, 0);
        // R8: read crossing the ROM end
        issue("R8", 1'b0, 2'b10, 32'h0800_00FE, 0);
        issue("R8", 1'b0, 2'b00, 32'h0912_3457, 0);
        // R5: EEPROM not configured, tag 0x0D reads ROM; writes are silent
        issue("R5", 1'b0, 2'b10, 32'h0D00_0004, 0);
        issue("R5", 1'b1, 2'b01, 32'h0D00_0000, 32'h1);
        idle(2);

        // R8: empty ROM pattern 00,00,01,00,02,00
        cfg_rom_bytes = 26'h0;
        issue("R8", 1'b0, 2'b10, 32'h0800_0000, 0);
        issue("R8", 1'b0, 2'b01, 32'h0800_0004, 0);
        idle(2);

        // R11 and R4: exactly 16 MiB is small; tag window selects EEPROM
        cfg_eeprom = 1'b1; cfg_rom_bytes = 26'h100_0000;
        issue("R7", 1'b0, 2'b01, 32'h0D00_0000, 0);
        issue("R6", 1'b1, 2'b01, 32'h0D00_ABCD, 32'h0000_0001);
        issue("R6", 1'b1, 2'b01, 32'h0D00_ABCD, 32'h0000_FFFE);
        issue("R11", 1'b0, 2'b10, 32'h09FF_FF00, 0);
        issue("R10", 1'b1, 2'b10, 32'h0800_0000, 32'hFFFF_FFFF);
        idle(2);

        // R3: large ROM moves the window to the top 256 bytes
        cfg_rom_bytes = 26'h100_0001;
        issue("R3", 1'b0, 2'b10, 32'h09FF_FF00, 0);
        issue("R3", 1'b0, 2'b10, 32'h09FF_FEFF, 0);
        issue("R3", 1'b1, 2'b00, 32'h0DFF_FFFF, 32'h1);
        issue("R4", 1'b0, 2'b10, 32'h0D00_0010, 0);
        issue("R10", 1'b1, 2'b10, 32'h0800_0100, 32'h1);
        idle(4);

        if (q.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard left=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule